// File: doc/BRIEF.md
# Remote-Terminal Word DMA Handshake Controller

This block sits between the protocol core of a serial-bus remote terminal and an external parallel memory. It moves one 16-bit data word per request. For each word it runs a request/grant/acknowledge handshake with the memory side and puts out a 12-bit mailbox address. Transmit commands read words out of memory with an output enable. Receive commands write words into memory with a single-cycle write strobe.

The protocol core loads each new command word with a start pulse, together with a flag that marks a broadcast reception. After that, every word request from the core produces one memory access, or it is served from an internal register. The address is built from the command: a broadcast flag, a direction flag, the subaddress and a word index. The word index steps after each completed transfer. Mode commands in the two reserved subaddresses use the mode code as the word index. Two transmit mode codes take their data word from internal registers. If the grant does not arrive within the timeout window, the block flags a handshake failure, latches a status bit and abandons the message.

Top module: `rt_dma_handshake`

## Requirements
- R1: While acknowledge is low, the address reads bit 11 = broadcast flag (driven 0 for any transmit command), bit 10 = direction (1 = transmit), bits 9:5 = subaddress (command bits 9:5), bits 4:0 = word index. The command word carries the direction in bit 10 and the word count or mode code in bits 4:0.
- R2: For a subaddress from 1 to 30, the word index starts at 0 on each start pulse. It increments by one after each completed transfer and wraps from 31 to 0.
- R3: For subaddress 0 or 31, the word index of every transfer equals the mode code, and it does not step.
- R4: A word request accepted in cycle k drives request low from cycle k+1. Request stays low until grant is seen low at a clock edge. Acknowledge goes low at that edge, and request goes high at the same edge.
- R5: On a transmit, acknowledge and output enable are low together for exactly one cycle. The value on the data bus in that cycle appears on the returned-word output in the next cycle, which is also the cycle where word-done pulses.
- R6: On a receive, acknowledge is low for three cycles and the write strobe is low only in the middle one. The data bus carries the received word in all three cycles. Word-done pulses in the following cycle.
- R7: With the default parameters, the timeout is 2000 cycles (10 us at 200 MHz). If grant is still high at the 2000th edge after request went low, then at that edge request goes high, handshake-fail goes low, abort pulses for one cycle and bit 12 of the status word is set. If grant is low at that edge, the transfer proceeds normally. Handshake-fail returns high on the next start pulse. The status bit stays set until reset.
- R8: For transmit mode code 18 or 19 in subaddress 0 or 31, a word request makes no handshake. Word-done pulses in the next cycle, returning the command word loaded before the current one (code 18) or the status word (code 19).
- R9: After reset, request, acknowledge, output enable, write strobe and handshake-fail are high, and the status word and word-done are 0.
- R10: When no transfer is in progress, all handshake controls are high.
- R11: Word requests are ignored before the first start pulse, after an abort, and while a transfer is in progress. Start pulses are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_start_i | input | 1 | Load a new command and open a message |
| cmd_word_i | input | 16 | Command word sampled with the start pulse |
| bcast_i | input | 1 | Command was received as a broadcast |
| word_req_i | input | 1 | Core asks for one word transfer |
| rx_word_i | input | 16 | Received word to write, sampled with the request |
| word_done_o | output | 1 | One-cycle pulse when a word is finished |
| tx_word_o | output | 16 | Word read from memory or from internal registers |
| msg_abort_o | output | 1 | One-cycle pulse when a message is abandoned |
| bit_word_o | output | 16 | Status word, bit 12 = handshake failure seen |
| req_no | output | 1 | Transfer request, active low |
| grant_ni | input | 1 | Transfer grant from memory side, active low |
| ack_no | output | 1 | Transfer acknowledge and address valid, active low |
| oe_no | output | 1 | Memory output enable, active low |
| wr_no | output | 1 | Memory write strobe, active low |
| hs_fail_no | output | 1 | Handshake failure, active low |
| mem_addr_o | output | 12 | Mailbox address |
| mem_data_io | inout | 16 | Memory data bus, released to high impedance when idle |

## Verification
The bench places the grant exactly on the last edge inside the timeout window and then one cycle later. A design with an off-by-one window would either abort a legal transfer or accept a late one. It runs 33 reads in one message, so a word index that saturates or fails to wrap shows up at the 33rd address. It issues start and word pulses in the middle of a handshake and after an abort. A design that reloads its command or restarts a transfer would then show a wrong address or an extra request. It also reads the two internal mode codes, to catch a design that runs a memory cycle for them or returns the current command instead of the previous one.

// File: rtl/rtdh_pkg.sv
package rtdh_pkg;
  localparam int DATA_W    = 16;
  localparam int FIELD_W   = 5;
  localparam int ADDR_W    = 2 + 2 * FIELD_W;
  localparam int FAIL_BIT  = 12;

  localparam logic [FIELD_W-1:0] MC_TX_LAST = 5'd18;
  localparam logic [FIELD_W-1:0] MC_TX_BIT  = 5'd19;

  typedef struct packed {
    logic [FIELD_W-1:0] rt;
    logic               tx;
    logic [FIELD_W-1:0] sa;
    logic [FIELD_W-1:0] cnt;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WSET,
    ST_WSTB,
    ST_WHOLD
  } hs_state_e;

  function automatic logic is_mode_sa(input logic [FIELD_W-1:0] sa);
    return (sa == '0) || (sa == '1);
  endfunction
endpackage

// File: rtl/rtdh_grant_timer.sv
module rtdh_grant_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = en_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/rtdh_addr_gen.sv
module rtdh_addr_gen
  import rtdh_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               bcast_i,
  input  logic               tx_i,
  input  logic [FIELD_W-1:0] sa_i,
  input  logic [FIELD_W-1:0] word_init_i,
  input  logic               step_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic               bc_q, tx_q;
  logic [FIELD_W-1:0] sa_q, word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_q   <= 1'b0;
      tx_q   <= 1'b0;
      sa_q   <= '0;
      word_q <= '0;
    end else if (load_i) begin
      bc_q   <= bcast_i & ~tx_i;  // transmit is never broadcast
      tx_q   <= tx_i;
      sa_q   <= sa_i;
      word_q <= word_init_i;
    end else if (step_i) begin
      word_q <= word_q + 1'b1;
    end
  end

  assign addr_o = {bc_q, tx_q, sa_q, word_q};
endmodule

// File: rtl/rtdh_hs_fsm.sv
module rtdh_hs_fsm
  import rtdh_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  logic      tx_i,
  input  logic      grant_ni,
  input  logic      expired_i,
  output hs_state_e state_o,
  output logic      wait_o,
  output logic      fail_o,
  output logic      done_o,
  output logic      drive_o,
  output logic      req_no,
  output logic      ack_no,
  output logic      oe_no,
  output logic      wr_no
);
  hs_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:  if (go_i) st_q <= ST_REQ;
        ST_REQ: begin
          if (!grant_ni)      st_q <= tx_i ? ST_RD : ST_WSET;
          else if (expired_i) st_q <= ST_IDLE;
        end
        ST_RD:    st_q <= ST_IDLE;
        ST_WSET:  st_q <= ST_WSTB;
        ST_WSTB:  st_q <= ST_WHOLD;
        ST_WHOLD: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign wait_o  = (st_q == ST_REQ);
  assign fail_o  = (st_q == ST_REQ) && grant_ni && expired_i;
  assign done_o  = (st_q == ST_RD) || (st_q == ST_WHOLD);
  assign drive_o = (st_q == ST_WSET) || (st_q == ST_WSTB) || (st_q == ST_WHOLD);
  assign req_no  = (st_q != ST_REQ);
  assign ack_no  = (st_q == ST_IDLE) || (st_q == ST_REQ);
  assign oe_no   = (st_q != ST_RD);
  assign wr_no   = (st_q != ST_WSTB);
endmodule

// File: rtl/rt_dma_handshake.sv
module rt_dma_handshake
  import rtdh_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int TIMEOUT_US = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_start_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic              bcast_i,
  input  logic              word_req_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic              word_done_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              msg_abort_o,
  output logic [DATA_W-1:0] bit_word_o,
  output logic              req_no,
  input  logic              grant_ni,
  output logic              ack_no,
  output logic              oe_no,
  output logic              wr_no,
  output logic              hs_fail_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  inout  wire  [DATA_W-1:0] mem_data_io
);
  localparam int TO_CYC = CLK_MHZ * TIMEOUT_US;

  cmd_t      cmd_in, cur_q, last_q;
  hs_state_e st;
  logic      idle, accept, mode_in, int_in;
  logic      active_q, mode_q, int_q;
  logic      word_go, int_go;
  logic      wait_s, fail_s, done_s, drive_s, expired;
  logic      done_q, abort_q, fail_q, bitfail_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign cmd_in  = cmd_word_i;
  assign idle    = (st == ST_IDLE);
  assign accept  = msg_start_i && idle;
  assign mode_in = is_mode_sa(cmd_in.sa);
  assign int_in  = cmd_in.tx && mode_in &&
                   ((cmd_in.cnt == MC_TX_LAST) || (cmd_in.cnt == MC_TX_BIT));
  assign word_go = word_req_i && idle && active_q && !int_q;
  assign int_go  = word_req_i && idle && active_q && int_q;

  rtdh_hs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (word_go),
    .tx_i      (cur_q.tx),
    .grant_ni  (grant_ni),
    .expired_i (expired),
    .state_o   (st),
    .wait_o    (wait_s),
    .fail_o    (fail_s),
    .done_o    (done_s),
    .drive_o   (drive_s),
    .req_no    (req_no),
    .ack_no    (ack_no),
    .oe_no     (oe_no),
    .wr_no     (wr_no)
  );

  rtdh_grant_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wait_s),
    .expired_o (expired)
  );

  rtdh_addr_gen u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .bcast_i     (bcast_i),
    .tx_i        (cmd_in.tx),
    .sa_i        (cmd_in.sa),
    .word_init_i (mode_in ? cmd_in.cnt : '0),
    .step_i      (done_s && !mode_q),
    .addr_o      (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      last_q    <= '0;
      active_q  <= 1'b0;
      mode_q    <= 1'b0;
      int_q     <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      fail_q    <= 1'b0;
      bitfail_q <= 1'b0;
    end else begin
      done_q  <= done_s || int_go;
      abort_q <= fail_s;
      if (accept) begin
        last_q   <= cur_q;
        cur_q    <= cmd_in;
        active_q <= 1'b1;
        mode_q   <= mode_in;
        int_q    <= int_in;
        fail_q   <= 1'b0;
      end
      if (fail_s) begin
        active_q  <= 1'b0;
        fail_q    <= 1'b1;
        bitfail_q <= 1'b1;
      end
      if (word_go) wdata_q <= rx_word_i;
      if (st == ST_RD) rdata_q <= mem_data_io;
      else if (int_go) rdata_q <= (cur_q.cnt == MC_TX_LAST) ? last_q : bit_word_o;
    end
  end

  always_comb begin
    bit_word_o           = '0;
    bit_word_o[FAIL_BIT] = bitfail_q;
  end

  assign mem_data_io = drive_s ? wdata_q : {DATA_W{1'bz}};
  assign word_done_o = done_q;
  assign tx_word_o   = rdata_q;
  assign msg_abort_o = abort_q;
  assign hs_fail_no  = ~fail_q;
endmodule

// File: rtl/rtdh_checker.sv
module rtdh_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_ni,
  input logic req_no,
  input logic ack_no,
  input logic oe_no,
  input logic wr_no,
  input logic hs_fail_no,
  input logic msg_abort_o,
  input logic word_done_o,
  input logic fail_bit_i
);
  assert_ack_after_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> $past(!grant_ni) && $past(!req_no));
  assert_req_ack_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_no |-> ack_no);
  assert_oe_inside_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !ack_no && wr_no);
  assert_oe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |=> oe_no);
  assert_wr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |=> wr_no && !ack_no);
  assert_wr_after_setup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !ack_no && $past(!ack_no));
  assert_fail_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_fail_no) |-> msg_abort_o && fail_bit_i && req_no);
  assert_abort_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_abort_o |=> !msg_abort_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_o |-> req_no && ack_no && oe_no && wr_no);
endmodule

bind rt_dma_handshake rtdh_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_ni    (grant_ni),
  .req_no      (req_no),
  .ack_no      (ack_no),
  .oe_no       (oe_no),
  .wr_no       (wr_no),
  .hs_fail_no  (hs_fail_no),
  .msg_abort_o (msg_abort_o),
  .word_done_o (word_done_o),
  .fail_bit_i  (bit_word_o[12])
);

// File: tb/rt_dma_handshake_test.sv
`timescale 1ns/1ps
module rt_dma_handshake_test;
  localparam int TO = 200 * 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_start = 0, bcast = 0, word_req = 0, grant_n = 1;
  logic [15:0] cmd_word = '0, rx_word = '0, rd_val = '0;
  logic word_done, msg_abort, req_n, ack_n, oe_n, wr_n, hs_fail_n;
  logic [15:0] tx_word, bit_word;
  logic [11:0] addr;
  wire  [15:0] mem_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign mem_data = !oe_n ? rd_val : 16'hzzzz;

  rt_dma_handshake #(.CLK_MHZ(200), .TIMEOUT_US(10)) uut (
    .clk_i(clk), .rst_ni(rst_n), .msg_start_i(msg_start), .cmd_word_i(cmd_word),
    .bcast_i(bcast), .word_req_i(word_req), .rx_word_i(rx_word),
    .word_done_o(word_done), .tx_word_o(tx_word), .msg_abort_o(msg_abort),
    .bit_word_o(bit_word), .req_no(req_n), .grant_ni(grant_n), .ack_no(ack_n),
    .oe_no(oe_n), .wr_no(wr_n), .hs_fail_no(hs_fail_n), .mem_addr_o(addr),
    .mem_data_io(mem_data));

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  function automatic logic [11:0] mk(input bit b, input bit t, input int sa, input int w);
    return {b, t, 5'(sa), 5'(w)};
  endfunction

  function automatic logic [15:0] cw(input int rt, input bit t, input int sa, input int c);
    return {5'(rt), t, 5'(sa), 5'(c)};
  endfunction

  task automatic start_msg(input logic [15:0] c, input bit b);
    @(negedge clk); msg_start = 1; cmd_word = c; bcast = b;
    @(negedge clk); msg_start = 0; cmd_word = 16'h0; bcast = 0;
  endtask

  // request phase: g edges with grant high, then grant low for one edge
  task automatic req_phase(input int g, input bit poke, input string tag);
    @(negedge clk); word_req = 1;
    @(negedge clk); word_req = 0;
    chk({tag, " R4 req low"}, {req_n, ack_n}, 2'b01);
    if (poke) begin
      msg_start = 1; cmd_word = 16'hFFFF; word_req = 1;
    end
    for (int i = 0; i < g; i++) begin
      @(negedge clk);
      msg_start = 0; cmd_word = 16'h0; word_req = 0;
      chk({tag, " R4 wait"}, {req_n, ack_n, word_done}, 3'b010);
    end
    grant_n = 0;
  endtask

  task automatic do_read(input int g, input logic [11:0] ea, input logic [15:0] v,
                         input bit poke, input string tag);
    rd_val = v;
    req_phase(g, poke, tag);
    @(negedge clk); grant_n = 1; msg_start = 0; word_req = 0;
    chk({tag, " R5 rd ctl"}, {req_n, ack_n, oe_n, wr_n}, 4'b1001);
    chk({tag, " R1 addr"}, addr, ea);
    @(negedge clk);
    chk({tag, " R5 done"}, {word_done, req_n, ack_n, oe_n}, 4'b1111);
    chk({tag, " R5 data"}, tx_word, v);
    @(negedge clk);
    chk({tag, " R11 single"}, {word_done, req_n}, 2'b01);
  endtask

  task automatic do_write(input int g, input logic [11:0] ea, input logic [15:0] v,
                          input string tag);
    rx_word = v;
    req_phase(g, 0, tag);
    @(negedge clk); grant_n = 1; rx_word = 16'h0;
    chk({tag, " R6 setup"}, {req_n, ack_n, oe_n, wr_n}, 4'b1011);
    chk({tag, " R1 addr"}, addr, ea);
    chk({tag, " R6 data0"}, mem_data, v);
    @(negedge clk);
    chk({tag, " R6 strobe"}, {ack_n, wr_n}, 2'b00);
    chk({tag, " R6 data1"}, mem_data, v);
    @(negedge clk);
    chk({tag, " R6 hold"}, {ack_n, wr_n}, 2'b01);
    chk({tag, " R6 data2"}, mem_data, v);
    @(negedge clk);
    chk({tag, " R10 done"}, {word_done, req_n, ack_n, oe_n, wr_n}, 5'b11111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ctl", {req_n, ack_n, oe_n, wr_n, hs_fail_n}, 5'b11111);
    chk("R9 bit", bit_word, 16'h0);
    chk("R9 done", {word_done, msg_abort}, 2'b00);
    rst_n = 1;

    // R11: no message open yet
    @(negedge clk); word_req = 1;
    @(negedge clk); word_req = 0;
    chk("R11 no msg", {req_n, word_done}, 2'b10);
    @(negedge clk);
    chk("R11 no msg2", req_n, 1'b1);

    // R1 R2 R6: broadcast receive, subaddress 5
    start_msg(cw(1, 0, 5, 3), 1);
    do_write(0, mk(1, 0, 5, 0), 16'hA001, "rx0");
    do_write(2, mk(1, 0, 5, 1), 16'h5A02, "rx1");
    do_write(1, mk(1, 0, 5, 2), 16'hC303, "rx2");

    // R1: transmit with broadcast flag forced off; R11: pokes during handshake
    start_msg(cw(1, 1, 7, 2), 1);
    do_read(1, mk(0, 1, 7, 0), 16'h1234, 1, "tx0 R11 poke");
    do_read(0, mk(0, 1, 7, 1), 16'hFEDC, 0, "tx1");

    // R2: word index wraps after 32 transfers
    start_msg(cw(1, 1, 2, 0), 0);
    for (int i = 0; i < 33; i++)
      do_read(0, mk(0, 1, 2, i % 32), 16'(16'h0100 + i), 0, "R2 wrap");

    // R3: mode commands use the mode code as index
    start_msg(cw(1, 0, 31, 17), 0);
    do_write(0, mk(0, 0, 31, 17), 16'h7777, "R3 sync");
    do_write(1, mk(0, 0, 31, 17), 16'h8888, "R3 sync2");
    start_msg(cw(1, 1, 0, 16), 0);
    do_read(0, mk(0, 1, 0, 16), 16'h4242, 0, "R3 vector");

    // R7: grant on the last edge of the window is accepted
    start_msg(cw(1, 1, 3, 4), 0);
    do_read(TO - 1, mk(0, 1, 3, 0), 16'h9999, 0, "R7 edge ok");
    chk("R7 no fail", {hs_fail_n, bit_word[12]}, 2'b10);

    // R7: one cycle late aborts
    @(negedge clk); word_req = 1;
    @(negedge clk); word_req = 0;
    chk("R7 req", req_n, 1'b0);
    for (int i = 0; i < TO - 1; i++) @(negedge clk);
    chk("R7 still req", req_n, 1'b0);
    @(negedge clk);
    chk("R7 fail ctl", {req_n, ack_n, hs_fail_n, msg_abort}, 4'b1101);
    chk("R7 bit12", bit_word, 16'h1000);
    @(negedge clk);
    chk("R7 abort pulse", {msg_abort, hs_fail_n}, 2'b00);
    word_req = 1;
    @(negedge clk); word_req = 0;
    chk("R11 after abort", {req_n, word_done}, 2'b10);
    @(negedge clk);
    chk("R11 after abort2", req_n, 1'b1);

    // R8: internal mode codes, no handshake
    start_msg(cw(2, 1, 9, 4), 0);
    chk("R7 fail cleared", {hs_fail_n, bit_word[12]}, 2'b11);
    start_msg(cw(3, 1, 0, 18), 0);
    @(negedge clk); word_req = 1;
    @(negedge clk); word_req = 0;
    chk("R8 last cmd", {word_done, req_n, ack_n}, 3'b111);
    chk("R8 last cmd data", tx_word, cw(2, 1, 9, 4));
    start_msg(cw(3, 1, 31, 19), 0);
    @(negedge clk); word_req = 1;
    @(negedge clk); word_req = 0;
    chk("R8 bit word", {word_done, req_n, ack_n}, 3'b111);
    chk("R8 bit data", tx_word, 16'h1000);
    @(negedge clk);
    chk("R8 no req", {word_done, req_n}, 2'b01);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule